// File: doc/BRIEF.md
# Controller state and sticky error register

This block keeps the operational state of a serial peripheral controller: whether it is running or held in configuration mode, whether it acts as bus master, and six sticky error flags. Five of the flags are transmit overflow, receive overflow, abort, transmit underflow and receive underflow. The sixth is a mode error.

Software never writes a state bit directly. It writes a 16-bit command word in which every state bit has its own set bit and its own clear bit. Bits that are written as 0 leave their flag alone, so a single access can change any subset of flags without first reading the register.

The shift engine reports error events on a 5-bit input. Each event is latched only when its matching capture-enable bit is 1. Any latched error, together with an interrupt enable, raises an error interrupt request. A status word gathers all of this state, plus the engine's busy signal, at fixed bit positions.

Top module: `ssr_state_reg`

## Requirements
- R1: With `rst` high at a clock edge, all flags clear. After that edge, `status` is zero except bit 13, `run_mode` and `master_mode` are 0, and `err_irq` is 0.
- R2: In a write (`cmd_wr`=1), command bit 1 sets the run flag (status bit 0, `run_mode`=1) and command bit 0 clears it (configuration mode).
- R3: Command bit 3 sets the master flag (status bit 1, `master_mode`) and command bit 2 clears it.
- R4: Command bits 12, 13, 14 and 15 set, and bits 8, 9, 10 and 11 clear, the following flags in this order: transmit overflow (status bit 8), receive overflow (bit 9), abort (bit 10) and transmit underflow (bit 11).
- R5: Command bit 5 sets and bit 4 clears receive underflow (status bit 12). Command bit 7 sets and bit 6 clears mode error (status bit 7).
- R6: A write that asserts both the set bit and the clear bit of a flag leaves that flag unchanged.
- R7: `hw_err` bits 0 to 4 report transmit overflow, receive overflow, abort, transmit underflow and receive underflow. An event whose `err_en` bit at the same index is 1 sets the matching flag (status bits 8 to 12).
- R8: An event whose `err_en` bit is 0 has no effect on its flag.
- R9: An enabled event in the same cycle as a software clear of that flag leaves the flag set.
- R10: Writing 0x0F50 clears all six error flags in one access and leaves the run and master flags unchanged.
- R11: `err_irq` is 1 exactly when `irq_en` is 1 and at least one of the six error flags is set.
- R12: Status bit 13 shows `busy` in the same cycle. Status bits 2 to 6, 14 and 15 read 0.
- R13: While `cmd_wr` is 0, `cmd_data` has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 16 | Set/clear command word |
| err_en | input | 5 | Per-error capture enables |
| hw_err | input | 5 | Error event pulses from the shift engine |
| irq_en | input | 1 | Error interrupt enable |
| busy | input | 1 | Shift engine busy, shown in status |
| status | output | 16 | Packed state and error view |
| run_mode | output | 1 | 1 = run mode, 0 = configuration mode |
| master_mode | output | 1 | Master select state |
| err_irq | output | 1 | Error interrupt request |

## Verification
Every flag is a single register. A write or error event presented before clock edge N is therefore visible on `status`, `run_mode` and `master_mode` just after edge N. `err_irq` and status bit 13 follow their inputs combinationally from those registers.

The driver applies each stimulus on a falling edge and pushes the expected values into a queue. The monitor pops the queue and compares one time unit after the next rising edge, which is exactly the cycle in which each result is due.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int CMD_W  = 16;
    localparam int STAT_W = 16;
    localparam int NUM_ERR = 5;
    localparam int NUM_FLAGS = 8;

    // flag indices inside the flag vector
    localparam int F_RUN   = 0;
    localparam int F_MST   = 1;
    localparam int F_ERR0  = 2;  // tx overflow, rx overflow, abort, tx underflow, rx underflow
    localparam int F_MODE  = 7;

    // status bit positions
    localparam int S_RUN  = 0;
    localparam int S_MST  = 1;
    localparam int S_MODE = 7;
    localparam int S_ERR0 = 8;
    localparam int S_BUSY = 13;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] set;
        logic [NUM_FLAGS-1:0] clr;
    } flag_cmd_t;

    function automatic flag_cmd_t decode_cmd(input logic [CMD_W-1:0] d);
        flag_cmd_t c;
        c.clr[F_RUN]       = d[0];
        c.set[F_RUN]       = d[1];
        c.clr[F_MST]       = d[2];
        c.set[F_MST]       = d[3];
        c.clr[F_ERR0+4]    = d[4];
        c.set[F_ERR0+4]    = d[5];
        c.clr[F_MODE]      = d[6];
        c.set[F_MODE]      = d[7];
        for (int i = 0; i < 4; i++) begin
            c.clr[F_ERR0+i] = d[8+i];
            c.set[F_ERR0+i] = d[12+i];
        end
        return c;
    endfunction
endpackage

// File: rtl/ssr_cmd_decode.sv
module ssr_cmd_decode
    import ssr_pkg::*;
(
    input  logic             wr_i,
    input  logic [CMD_W-1:0] data_i,
    output flag_cmd_t        cmd_o
);
    flag_cmd_t raw;

    always_comb begin
        raw   = decode_cmd(data_i);
        cmd_o = wr_i ? raw : '0;
    end
endmodule

// File: rtl/ssr_flag.sv
module ssr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic hw_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (hw_i)
            q <= 1'b1;          // hardware event wins over a clear
        else if (set_i && clr_i)
            q <= q;             // conflicting request: hold
        else if (set_i)
            q <= 1'b1;
        else if (clr_i)
            q <= 1'b0;
    end
endmodule

// File: rtl/ssr_status_pack.sv
module ssr_status_pack
    import ssr_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic                 busy_i,
    output logic [STAT_W-1:0]    status_o
);
    always_comb begin
        status_o = '0;
        status_o[S_RUN]  = flags_i[F_RUN];
        status_o[S_MST]  = flags_i[F_MST];
        status_o[S_MODE] = flags_i[F_MODE];
        status_o[S_ERR0 +: NUM_ERR] = flags_i[F_ERR0 +: NUM_ERR];
        status_o[S_BUSY] = busy_i;
    end
endmodule

// File: rtl/ssr_state_reg.sv
module ssr_state_reg
    import ssr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic [NUM_ERR-1:0] err_en,
    input  logic [NUM_ERR-1:0] hw_err,
    input  logic              irq_en,
    input  logic              busy,
    output logic [STAT_W-1:0] status,
    output logic              run_mode,
    output logic              master_mode,
    output logic              err_irq
);
    flag_cmd_t            cmd;
    logic [NUM_FLAGS-1:0] hw_vec;
    logic [NUM_FLAGS-1:0] flags;

    ssr_cmd_decode u_dec (
        .wr_i   (cmd_wr),
        .data_i (cmd_data),
        .cmd_o  (cmd)
    );

    always_comb begin
        hw_vec = '0;
        hw_vec[F_ERR0 +: NUM_ERR] = hw_err & err_en;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_FLAGS; g++) begin : g_flag
            ssr_flag u_flag (
                .clk   (clk),
                .rst   (rst),
                .set_i (cmd.set[g]),
                .clr_i (cmd.clr[g]),
                .hw_i  (hw_vec[g]),
                .q     (flags[g])
            );
        end
    endgenerate

    ssr_status_pack u_pack (
        .flags_i  (flags),
        .busy_i   (busy),
        .status_o (status)
    );

    assign run_mode    = flags[F_RUN];
    assign master_mode = flags[F_MST];
    assign err_irq     = irq_en && (|flags[F_ERR0 +: NUM_ERR] || flags[F_MODE]);
endmodule

// File: rtl/ssr_state_reg_chk.sv
module ssr_state_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_wr,
    input logic [15:0] cmd_data,
    input logic [4:0]  err_en,
    input logic [4:0]  hw_err,
    input logic        irq_en,
    input logic [15:0] status,
    input logic        err_irq
);
    // R2
    run_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data[1] && !cmd_data[0]) |=> status[0]);

    // R6
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data[3] && cmd_data[2]) |=> $stable(status[1]));

    // R7
    hw_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_err[0] && err_en[0]) |=> status[8]);

    // R8
    hw_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && !(hw_err[2] && err_en[2])) |=> $stable(status[10]));

    // R10
    clr_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data == 16'h0F50 && ((hw_err & err_en) == 5'd0))
        |=> (status[12:8] == 5'd0 && !status[7]));

    // R11
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !err_irq);
endmodule

bind ssr_state_reg ssr_state_reg_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_data (cmd_data),
    .err_en   (err_en),
    .hw_err   (hw_err),
    .irq_en   (irq_en),
    .status   (status),
    .err_irq  (err_irq)
);

// File: tb/tb_ssr_state_reg.sv
module tb_ssr_state_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [4:0]  err_en = '0;
    logic [4:0]  hw_err = '0;
    logic        irq_en = 1'b0;
    logic        busy = 1'b0;
    logic [15:0] status;
    logic        run_mode;
    logic        master_mode;
    logic        err_irq;

    ssr_state_reg dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .err_en(err_en), .hw_err(hw_err), .irq_en(irq_en), .busy(busy),
        .status(status), .run_mode(run_mode), .master_mode(master_mode),
        .err_irq(err_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [15:0] st;
        logic        run;
        logic        mst;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    bit m_run, m_mst, m_mode;
    bit [4:0] m_err;

    function automatic bit nxt(bit cur, bit s, bit c, bit h);
        if (h) return 1'b1;
        if (s && c) return cur;
        if (s) return 1'b1;
        if (c) return 1'b0;
        return cur;
    endfunction

    task automatic step(input bit r, input bit wr, input logic [15:0] d,
                        input logic [4:0] hw, input logic [4:0] en,
                        input bit ie, input bit bz, input string tag);
        exp_t e;
        bit [15:0] dd;
        @(negedge clk);
        rst = r; cmd_wr = wr; cmd_data = d; hw_err = hw; err_en = en;
        irq_en = ie; busy = bz;
        dd = wr ? d : 16'h0;
        if (r) begin
            m_run = 0; m_mst = 0; m_mode = 0; m_err = '0;
        end else begin
            m_run  = nxt(m_run, dd[1], dd[0], 1'b0);
            m_mst  = nxt(m_mst, dd[3], dd[2], 1'b0);
            m_mode = nxt(m_mode, dd[7], dd[6], 1'b0);
            for (int i = 0; i < 4; i++)
                m_err[i] = nxt(m_err[i], dd[12+i], dd[8+i], hw[i] & en[i]);
            m_err[4] = nxt(m_err[4], dd[5], dd[4], hw[4] & en[4]);
        end
        e.st = 16'h0;
        e.st[0] = m_run; e.st[1] = m_mst; e.st[7] = m_mode;
        e.st[12:8] = m_err; e.st[13] = bz;
        e.run = m_run; e.mst = m_mst;
        e.irq = ie && ((|m_err) || m_mode);
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares just after the edge at which each result is due
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (status !== e.st || run_mode !== e.run ||
                    master_mode !== e.mst || err_irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: status=%h run=%b mst=%b irq=%b expected status=%h run=%b mst=%b irq=%b",
                             e.tag, status, run_mode, master_mode, err_irq,
                             e.st, e.run, e.mst, e.irq);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 0, 16'h0, 5'h0, 5'h0, 0, 0, "R1");
        step(1, 1, 16'hFFFF, 5'h1F, 5'h1F, 1, 0, "R1");
        // R2 run/config
        step(0, 1, 16'h0002, 0, 0, 0, 0, "R2");
        step(0, 1, 16'h0001, 0, 0, 0, 0, "R2");
        step(0, 1, 16'h0002, 0, 0, 0, 0, "R2");
        // R3 master
        step(0, 1, 16'h0008, 0, 0, 0, 0, "R3");
        step(0, 1, 16'h0004, 0, 0, 0, 0, "R3");
        step(0, 1, 16'h0008, 0, 0, 0, 0, "R3");
        // R13 no write strobe
        step(0, 0, 16'hFFFF, 0, 0, 0, 0, "R13");
        step(0, 0, 16'h0F55, 0, 0, 0, 0, "R13");
        // R4 four flags
        step(0, 1, 16'hF000, 0, 0, 0, 0, "R4");
        step(0, 1, 16'h0100, 0, 0, 0, 0, "R4");
        step(0, 1, 16'h0A00, 0, 0, 0, 0, "R4");
        step(0, 1, 16'h0400, 0, 0, 0, 0, "R4");
        // R5 rx underflow and mode error
        step(0, 1, 16'h0020, 0, 0, 0, 0, "R5");
        step(0, 1, 16'h0080, 0, 0, 0, 0, "R5");
        step(0, 1, 16'h0010, 0, 0, 0, 0, "R5");
        step(0, 1, 16'h0040, 0, 0, 0, 0, "R5");
        // R6 conflicting set and clear
        step(0, 1, 16'h0003, 0, 0, 0, 0, "R6");
        step(0, 1, 16'h000C, 0, 0, 0, 0, "R6");
        step(0, 1, 16'h1100, 0, 0, 0, 0, "R6");
        step(0, 1, 16'h2000, 0, 0, 0, 0, "R6");
        step(0, 1, 16'h2200, 0, 0, 0, 0, "R6");
        step(0, 1, 16'h0200, 0, 0, 0, 0, "R6");
        // R11 interrupt
        step(0, 1, 16'h0080, 0, 0, 1, 0, "R11");
        step(0, 0, 16'h0, 0, 0, 0, 0, "R11");
        step(0, 1, 16'h0040, 0, 0, 1, 0, "R11");
        step(0, 1, 16'h0020, 0, 0, 1, 0, "R11");
        step(0, 1, 16'h0010, 0, 0, 1, 0, "R11");
        // R7 each event with enable
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 16'h0, 5'(1 << i), 5'h1F, 1, 0, "R7");
            step(0, 1, 16'h0F50, 0, 5'h1F, 0, 0, "R7");
        end
        // R8 masked events
        step(0, 0, 16'h0, 5'h1F, 5'h00, 1, 0, "R8");
        step(0, 0, 16'h0, 5'h1F, 5'h15, 1, 0, "R8");
        step(0, 0, 16'h0, 5'h00, 5'h1F, 1, 0, "R8");
        // R9 event meets clear
        step(0, 1, 16'h0F50, 5'h01, 5'h01, 0, 0, "R9");
        step(0, 1, 16'h0F50, 5'h10, 5'h10, 0, 0, "R9");
        step(0, 1, 16'h0F50, 5'h10, 5'h00, 0, 0, "R9");
        // R10 clear all errors
        step(0, 1, 16'hF0A0, 0, 0, 1, 0, "R10");
        step(0, 1, 16'h0F50, 0, 0, 1, 0, "R10");
        // R12 busy passthrough
        step(0, 0, 16'h0, 0, 0, 0, 1, "R12");
        step(0, 0, 16'h0, 0, 0, 0, 0, "R12");
        // R1 reset from populated state
        step(0, 1, 16'hF0AA, 0, 0, 1, 0, "R1");
        step(1, 0, 16'h0, 0, 0, 1, 1, "R1");
        step(0, 0, 16'h0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule